// File: doc/BRIEF.md
# Per-Block Hysteresis Threshold Calculator

This block chooses the pair of hysteresis thresholds for a single image block of an edge detector, using only that block's own gradient magnitudes after non-maximum suppression. Each magnitude is stored as it arrives, and the block's smallest and largest values are tracked. When the block ends, the span between the smallest and largest value is cut into eight equal-width levels. Every stored magnitude is then placed in a level, which builds a coarse histogram.

A target count is then formed from the strong-edge fraction `p1_frac`, given as an unsigned Q0.8 value. The target is `ceil(p1_frac * N / 256)`, where N is the number of pixels in the block. The histogram is walked from the highest level downward, adding up the pixel counts. The first level at which the running count reaches the target sets the high threshold, which is that level's lower edge. The low threshold is then about 40% of the high one. A one-cycle `done` pulse shows that both results are valid, and they stay unchanged until the next `done`.

Magnitudes enter on a valid/ready stream. `mag_ready` is high only while a block is being collected. A beat moves when `mag_valid` and `mag_ready` are both high in the same cycle, so an upstream source simply holds its beat until ready returns. Ready drops after the final beat of a block and stays low until the next block is opened with `blk_start` while the block is idle. `blk_start` has no effect at any other time.

Top module: `blk_thresh_calc`

## Requirements
- R1: After reset, `done`, `mag_ready`, `thr_high` and `thr_low` are all 0.
- R2: `mag_ready` is low while idle and from the final beat of a block until the next accepted `blk_start`. A `mag_valid` beat presented while `mag_ready` is low is neither stored nor counted and does not change the result.
- R3: `done` is high for exactly one cycle per block. It rises no later than N + 11 cycles after the final beat, where N is the block's pixel count and 11 is the number of levels plus 3.
- R4: Let lo and hi be the block's smallest and largest magnitude. Level k (k = 0..7) has lower edge b_k = lo + ((k*(hi-lo)) >> 3). A pixel's level is the largest k with magnitude >= b_k. Let T = ceil(p1_frac*N/256). `thr_high` is b_i, where i is the highest level at which the count of pixels in levels i..7 is at least T.
- R5: `thr_low` equals `(thr_high * 102) >> 8`.
- R6: When `p1_frac` is 0, or when every magnitude of the block is 0, `thr_high` is hi + 1, so that no pixel reaches the strong-edge threshold.
- R7: When every magnitude equals the same nonzero value v and `p1_frac` is nonzero, `thr_high` is v.
- R8: The beat that fills the 64-entry store ends the block even when `mag_last` is low.
- R9: The histogram, the extremes and the pixel count are cleared when a block starts, so a result depends only on that block's own magnitudes.
- R10: `thr_high` and `thr_low` keep their values in every cycle in which `done` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Opens a new block when the block is idle |
| p1_frac | input | P1_W (8) | Strong-edge fraction, unsigned Q0.8; held until `done` |
| mag_valid | input | 1 | Magnitude beat valid |
| mag_ready | output | 1 | Block accepts a magnitude beat |
| mag_data | input | MAG_W (8) | Gradient magnitude after suppression |
| mag_last | input | 1 | Marks the final beat of the block |
| thr_high | output | MAG_W+1 (9) | High hysteresis threshold |
| thr_low | output | MAG_W+1 (9) | Low hysteresis threshold |
| done | output | 1 | One-cycle pulse when both thresholds are valid |

## Verification
The main function is tried with a linear ramp and with scattered pseudo-random values. Together these separate the level edges, the top-down walk and the target rounding. A flat block, a block of all zeros and a block with `p1_frac` set to 0 tell the degenerate paths apart from the normal walk. A narrow four-value span tests the truncating level arithmetic. A full store with no last flag is followed by a short block, which shows that ending on capacity works and that no histogram content carries over from one block to the next. Junk beats sent while ready is low would shift the extremes if they were taken in, so an unchanged result proves they are ignored.

// File: rtl/bthr_pkg.sv
package bthr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COLLECT,
    ST_PREP,
    ST_BIN,
    ST_WALK
  } bthr_state_e;

endpackage

// File: rtl/bthr_store.sv
module bthr_store #(
  parameter int MAG_W = 8,
  parameter int DEPTH = 64,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [MAG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [MAG_W-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic [MAG_W-1:0] mag_min,
  output logic [MAG_W-1:0] mag_max
);

  logic [MAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[count[IDX_W-1:0]] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      mag_min <= '1;
      mag_max <= '0;
    end else if (clr) begin
      count   <= '0;
      mag_min <= '1;
      mag_max <= '0;
    end else if (wr_en) begin
      count <= count + CNT_W'(1);
      if (wr_data < mag_min) mag_min <= wr_data;
      if (wr_data > mag_max) mag_max <= wr_data;
    end
  end

  // R8: no write is ever issued once the store holds DEPTH entries
  p_store_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (count < CNT_W'(DEPTH)));

endmodule

// File: rtl/bthr_hist.sv
module bthr_hist #(
  parameter int MAG_W  = 8,
  parameter int DEPTH  = 64,
  parameter int LEVELS = 8,
  parameter int LVL_W  = $clog2(LEVELS),
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             prep,
  input  logic [MAG_W-1:0] mag_min,
  input  logic [MAG_W-1:0] mag_max,
  input  logic             bin_en,
  input  logic [MAG_W-1:0] bin_mag,
  input  logic [LVL_W-1:0] lvl_sel,
  output logic [CNT_W-1:0] lvl_count,
  output logic [MAG_W-1:0] lvl_base
);

  localparam int PROD_W = MAG_W + LVL_W;
  localparam int SUM_W  = CNT_W + LVL_W;

  logic [MAG_W-1:0] base_d [LEVELS];
  logic [MAG_W-1:0] base_q [LEVELS];
  logic [CNT_W-1:0] hist_q [LEVELS];
  logic [LVL_W-1:0] bin_lvl;
  logic [SUM_W-1:0] hist_sum;

  for (genvar k = 0; k < LEVELS; k++) begin : g_edge
    logic [PROD_W-1:0] scaled;
    assign scaled    = PROD_W'(k) * PROD_W'(mag_max - mag_min);
    assign base_d[k] = mag_min + MAG_W'(scaled >> LVL_W);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LEVELS; k++) base_q[k] <= '0;
    end else if (prep) begin
      for (int k = 0; k < LEVELS; k++) base_q[k] <= base_d[k];
    end
  end

  always_comb begin
    bin_lvl = '0;
    for (int k = 1; k < LEVELS; k++) begin
      if (bin_mag >= base_q[k]) bin_lvl = LVL_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < LEVELS; k++) hist_q[k] <= '0;
    end else if (bin_en) begin
      hist_q[bin_lvl] <= hist_q[bin_lvl] + CNT_W'(1);
    end
  end

  assign lvl_count = hist_q[lvl_sel];
  assign lvl_base  = base_q[lvl_sel];

  always_comb begin
    hist_sum = '0;
    for (int k = 0; k < LEVELS; k++) hist_sum = hist_sum + SUM_W'(hist_q[k]);
  end

  // R4: binning never files more pixels than a block can hold
  p_hist_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bin_en |-> (hist_sum < SUM_W'(DEPTH)));

  // R9: a cleared histogram is empty on the following cycle
  p_hist_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hist_sum == '0));

endmodule

// File: rtl/bthr_select.sv
module bthr_select #(
  parameter int MAG_W  = 8,
  parameter int P1_W   = 8,
  parameter int LEVELS = 8,
  parameter int LVL_W  = $clog2(LEVELS),
  parameter int CNT_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [P1_W-1:0]  p1,
  input  logic [CNT_W-1:0] npix,
  input  logic [MAG_W-1:0] mag_max,
  input  logic [CNT_W-1:0] lvl_count,
  input  logic [MAG_W-1:0] lvl_base,
  output logic [LVL_W-1:0] lvl_sel,
  output logic             found,
  output logic [MAG_W:0]   thh
);

  localparam int PW = P1_W + CNT_W;

  logic             active_q, spec_q, found_q;
  logic [LVL_W-1:0] lvl_q;
  logic [CNT_W-1:0] cum_q, tgt_q, cum_nxt;
  logic [MAG_W-1:0] max_q;
  logic [MAG_W:0]   thh_q;
  logic [PW-1:0]    tgt_full;

  assign tgt_full = (PW'(p1) * PW'(npix) + PW'((1 << P1_W) - 1)) >> P1_W;
  assign cum_nxt  = cum_q + lvl_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      spec_q   <= 1'b0;
      found_q  <= 1'b0;
      lvl_q    <= '0;
      cum_q    <= '0;
      tgt_q    <= '0;
      max_q    <= '0;
      thh_q    <= '0;
    end else begin
      found_q <= 1'b0;
      if (go) begin
        active_q <= 1'b1;
        spec_q   <= (p1 == '0) || (mag_max == '0);
        max_q    <= mag_max;
        tgt_q    <= CNT_W'(tgt_full);
        cum_q    <= '0;
        lvl_q    <= LVL_W'(LEVELS - 1);
      end else if (active_q) begin
        if (spec_q) begin
          found_q  <= 1'b1;
          thh_q    <= {1'b0, max_q} + (MAG_W+1)'(1);
          active_q <= 1'b0;
        end else if ((cum_nxt >= tgt_q) || (lvl_q == '0)) begin
          found_q  <= 1'b1;
          thh_q    <= {1'b0, lvl_base};
          active_q <= 1'b0;
        end else begin
          cum_q <= cum_nxt;
          lvl_q <= lvl_q - LVL_W'(1);
        end
      end
    end
  end

  assign lvl_sel = lvl_q;
  assign found   = found_q;
  assign thh     = thh_q;

  // R4: the bottom level always completes the target count
  p_walk_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !spec_q && !go && (lvl_q == '0)) |-> (cum_nxt >= tgt_q));

  // R6: a chosen threshold never exceeds the block maximum plus one
  p_thh_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    found_q |-> (thh_q <= ({1'b0, max_q} + (MAG_W+1)'(1))));

endmodule

// File: rtl/blk_thresh_calc.sv
module blk_thresh_calc
  import bthr_pkg::*;
#(
  parameter int MAG_W   = 8,
  parameter int P1_W    = 8,
  parameter int DEPTH   = 64,
  parameter int LEVELS  = 8,
  parameter int LOW_NUM = 102,
  parameter int LOW_SH  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic [P1_W-1:0]  p1_frac,
  input  logic             mag_valid,
  output logic             mag_ready,
  input  logic [MAG_W-1:0] mag_data,
  input  logic             mag_last,
  output logic [MAG_W:0]   thr_high,
  output logic [MAG_W:0]   thr_low,
  output logic             done
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int LVL_W = $clog2(LEVELS);
  localparam int TH_W  = MAG_W + 1;
  localparam int LOW_W = $clog2(LOW_NUM + 1);
  localparam int PRD_W = TH_W + LOW_W;

  bthr_state_e      state_q;
  logic [IDX_W-1:0] rd_idx_q;
  logic [MAG_W-1:0] rd_data, mag_min, mag_max, lvl_base;
  logic [CNT_W-1:0] count, lvl_count;
  logic [LVL_W-1:0] lvl_sel;
  logic [TH_W-1:0]  thh;
  logic [PRD_W-1:0] low_prod;
  logic             clr, beat, end_beat, bin_last, go, found;

  assign mag_ready = (state_q == ST_COLLECT);
  assign clr       = blk_start && (state_q == ST_IDLE);
  assign beat      = mag_valid && mag_ready;
  assign end_beat  = beat && (mag_last || (count == CNT_W'(DEPTH - 1)));
  assign bin_last  = (state_q == ST_BIN) && (CNT_W'(rd_idx_q) == count - CNT_W'(1));
  assign go        = bin_last;
  assign low_prod  = PRD_W'(thh) * PRD_W'(LOW_NUM);

  bthr_store #(
    .MAG_W(MAG_W), .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(beat), .wr_data(mag_data),
    .rd_idx(rd_idx_q), .rd_data(rd_data), .count(count),
    .mag_min(mag_min), .mag_max(mag_max)
  );

  bthr_hist #(
    .MAG_W(MAG_W), .DEPTH(DEPTH), .LEVELS(LEVELS), .LVL_W(LVL_W), .CNT_W(CNT_W)
  ) u_hist (
    .clk(clk), .rst_n(rst_n), .clr(clr), .prep(state_q == ST_PREP),
    .mag_min(mag_min), .mag_max(mag_max), .bin_en(state_q == ST_BIN),
    .bin_mag(rd_data), .lvl_sel(lvl_sel), .lvl_count(lvl_count),
    .lvl_base(lvl_base)
  );

  bthr_select #(
    .MAG_W(MAG_W), .P1_W(P1_W), .LEVELS(LEVELS), .LVL_W(LVL_W), .CNT_W(CNT_W)
  ) u_select (
    .clk(clk), .rst_n(rst_n), .go(go), .p1(p1_frac), .npix(count),
    .mag_max(mag_max), .lvl_count(lvl_count), .lvl_base(lvl_base),
    .lvl_sel(lvl_sel), .found(found), .thh(thh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      rd_idx_q <= '0;
      thr_high <= '0;
      thr_low  <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE:    if (clr) state_q <= ST_COLLECT;
        ST_COLLECT: if (end_beat) state_q <= ST_PREP;
        ST_PREP: begin
          rd_idx_q <= '0;
          state_q  <= ST_BIN;
        end
        ST_BIN: begin
          rd_idx_q <= rd_idx_q + IDX_W'(1);
          if (bin_last) state_q <= ST_WALK;
        end
        ST_WALK: if (found) begin
          thr_high <= thh;
          thr_low  <= TH_W'(low_prod >> LOW_SH);
          done     <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: done lasts a single cycle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: ready falls right after the final beat
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mag_last) |=> !mag_ready);

  // R5: the published pair keeps the low/high ratio
  p_low_ratio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (thr_low == TH_W'((PRD_W'(thr_high) * PRD_W'(LOW_NUM)) >> LOW_SH)));

  // R10: results only move together with done
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(thr_high) && $stable(thr_low)));

endmodule

// File: tb/blk_thresh_calc_bench.sv
module blk_thresh_calc_bench;

  localparam int LEVELS = 8;

  logic       clk = 1'b0, rst_n = 1'b0, blk_start = 1'b0;
  logic       mag_valid = 1'b0, mag_last = 1'b0;
  logic [7:0] p1_frac = '0, mag_data = '0;
  logic       mag_ready, done;
  logic [8:0] thr_high, thr_low;

  always #4 clk = ~clk;

  blk_thresh_calc u_blk_thresh_calc (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .p1_frac(p1_frac),
    .mag_valid(mag_valid), .mag_ready(mag_ready), .mag_data(mag_data),
    .mag_last(mag_last), .thr_high(thr_high), .thr_low(thr_low), .done(done)
  );

  typedef struct {
    logic [8:0] thh;
    logic [8:0] thl;
    int         n;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         compared = 0, mismatched = 0;
  int         cyc = 0, last_cyc = 0;
  bit         prev_done = 1'b0;
  logic [8:0] held_thh = '0, held_thl = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model_thh(input logic [7:0] m[], input int p1v);
    int mn = 255, mx = 0, n = m.size(), tgt, cum = 0, lvl;
    int base[8];
    int hist[8];
    foreach (m[i]) begin
      if (int'(m[i]) < mn) mn = int'(m[i]);
      if (int'(m[i]) > mx) mx = int'(m[i]);
    end
    if (p1v == 0 || mx == 0) return 9'(mx + 1);
    for (int k = 0; k < 8; k++) begin
      base[k] = mn + ((k * (mx - mn)) >> 3);
      hist[k] = 0;
    end
    foreach (m[i]) begin
      lvl = 0;
      for (int k = 1; k < 8; k++) if (int'(m[i]) >= base[k]) lvl = k;
      hist[lvl]++;
    end
    tgt = (p1v * n + 255) >> 8;
    for (int l = 7; l >= 0; l--) begin
      cum += hist[l];
      if (cum >= tgt) return 9'(base[l]);
    end
    return 9'(base[0]);
  endfunction

  function automatic logic [8:0] model_thl(input logic [8:0] h);
    return 9'((int'(h) * 102) >> 8);
  endfunction

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    exp_t e;
    cyc++;
    if (rst_n) begin
      if (done && prev_done) check(1'b0, "R3 done wider than one cycle", 1, 0);
      if (done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3 done with nothing expected", 1, 0);
        end else begin
          e = sb.pop_front();
          check(thr_high == e.thh, {e.tag, " thr_high"}, int'(thr_high), int'(e.thh));
          check(thr_low == e.thl, {e.tag, " R5 thr_low"}, int'(thr_low), int'(e.thl));
          check((cyc - last_cyc) <= e.n + LEVELS + 4, {e.tag, " R3 latency"},
                cyc - last_cyc, e.n + LEVELS + 4);
          held_thh = thr_high;
          held_thl = thr_low;
        end
      end
    end
    prev_done = done;
  end

  task automatic run_block(input logic [7:0] m[], input int p1v, input bit use_last,
                           input string tag);
    exp_t e;
    wait (sb.size() == 0);
    @(negedge clk);
    // junk beats while idle must be ignored (R2)
    mag_valid = 1'b1; mag_data = 8'hFF; mag_last = 1'b1;
    repeat (2) begin
      @(negedge clk);
      check(!mag_ready, {tag, " R2 ready low while idle"}, int'(mag_ready), 0);
    end
    e.thh = model_thh(m, p1v);
    e.thl = model_thl(e.thh);
    e.n   = m.size();
    e.tag = tag;
    sb.push_back(e);
    p1_frac = 8'(p1v);
    mag_valid = 1'b0; mag_last = 1'b0;
    blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    for (int i = 0; i < m.size(); i++) begin
      if (i % 5 == 3) begin
        mag_valid = 1'b0;
        @(negedge clk);
      end
      while (!mag_ready) @(negedge clk);
      mag_valid = 1'b1;
      mag_data  = m[i];
      mag_last  = use_last && (i == m.size() - 1);
      @(negedge clk);
    end
    last_cyc = cyc;
    // junk after the final beat must be ignored (R2)
    mag_valid = 1'b1; mag_data = 8'hFF; mag_last = 1'b0;
    repeat (3) begin
      check(!mag_ready, {tag, " R2 ready low after final beat"}, int'(mag_ready), 0);
      @(negedge clk);
    end
    mag_valid = 1'b0;
    wait (sb.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] m[];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(mag_ready == 1'b0, "R1 ready after reset", int'(mag_ready), 0);
    check(thr_high == '0, "R1 thr_high after reset", int'(thr_high), 0);
    check(thr_low == '0, "R1 thr_low after reset", int'(thr_low), 0);

    // R4: ramp 0..63, p1 = 1/8 -> target 8, top level 55..63 holds 9
    m = new[64];
    foreach (m[i]) m[i] = 8'(i);
    check(model_thh(m, 32) == 9'd55, "R4 ramp hand value", int'(model_thh(m, 32)), 55);
    run_block(m, 32, 1'b1, "R4 ramp");

    // R10: results held while done is low
    repeat (6) @(negedge clk);
    check(thr_high == 9'd55, "R10 thr_high held", int'(thr_high), 55);
    check(thr_low == 9'd21, "R10 thr_low held", int'(thr_low), 21);

    // R7: flat nonzero block
    m = new[20];
    foreach (m[i]) m[i] = 8'd80;
    check(model_thh(m, 64) == 9'd80, "R7 flat hand value", int'(model_thh(m, 64)), 80);
    run_block(m, 64, 1'b1, "R7 flat");

    // R6: p1 of zero
    m = new[30];
    foreach (m[i]) m[i] = 8'((i * 13) % 150);
    m[5] = 8'd200;
    check(model_thh(m, 0) == 9'd201, "R6 p1 zero hand value", int'(model_thh(m, 0)), 201);
    run_block(m, 0, 1'b1, "R6 p1 zero");

    // R6: every magnitude zero
    m = new[16];
    foreach (m[i]) m[i] = 8'd0;
    run_block(m, 128, 1'b1, "R6 all zero");

    // R4: scattered values
    m = new[40];
    foreach (m[i]) m[i] = 8'((i * 73 + 11) % 256);
    run_block(m, 77, 1'b1, "R4 scattered");

    // R4: narrow span, truncating edges
    m = new[24];
    foreach (m[i]) m[i] = 8'(100 + i % 4);
    run_block(m, 100, 1'b1, "R4 narrow");

    // R8: full store without a last flag
    m = new[64];
    foreach (m[i]) m[i] = 8'((i * 29 + 7) % 256);
    run_block(m, 50, 1'b0, "R8 full store");

    // R9: short block right after the full one
    m = new[10];
    foreach (m[i]) m[i] = 8'(5 + i);
    run_block(m, 200, 1'b1, "R9 fresh histogram");

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule